// File: doc/BRIEF.md
# Packet Read Arbiter and Telemetry Byte Serializer

This block drains finished packets from a shared packet memory and sends them to a telemetry receiver. Four buffer owners raise a level request while they hold at least one complete, unread packet. The block grants one owner at a time in a fixed order. It reads that owner's whole packet, one 16-bit word per word slot, and sends each word as two bytes on an 8-bit bus. The bus has its own derived clock and an active-low sync line.

Everything runs on one system clock. A free-running four-cycle phase counter sets the word slot. The telemetry clock runs at half the system clock: it rises at the start of each byte and falls halfway through it, so the receiver can sample on the falling edge. For each owner the block keeps a read pointer into a ring of buffers. When a packet finishes, the block returns a one-cycle done pulse to that owner's writer.

Readout stops when the receiver's asynchronous ready input drops or when the inhibit control is set. A halt abandons the packet in progress without advancing any pointer, so the same buffer is read again from its first word once readout resumes.

Top module: `pkt_read_serializer`

## Requirements
- R1: While reset is held and directly after it, tlm_sync_n_o is 1, tlm_clk_o is 0, mem_rd_o is 0 and buf_done_o is 0.
- R2: Owner codes are 0 for event data, 1 for fast rate, 2 for monitor rate and 3 for pass-through. When several owners request at once, they are granted in the order 2, 0, 1, 3.
- R3: A grant reads PKT_WORDS words in consecutive word slots, one read (mem_rd_o high for one cycle) every four clocks. The address is {owner[1:0], buffer[BUF_W-1:0], word[IDX_W-1:0]} with the word index running from 0. No other owner is granted until the packet ends.
- R4: The owner whose packet has just ended is excluded from the next arbitration decision only. If two owners request all the time, their packets alternate.
- R5: Each word is sent as its high byte, then its low byte. tlm_clk_o is high for one clock and low for one clock. Data and sync change only when tlm_clk_o rises, and both are stable when it falls.
- R6: tlm_sync_n_o is 0 for every byte of a packet. Between back-to-back packets from the same owner it is 1 for exactly two telemetry clocks. When the next packet comes from a different owner, it stays 0.
- R7: While inhibit_i is 1, no read is issued and sync stays high. A packet in progress is dropped with no done pulse. After release, the same buffer is read again from word 0.
- R8: ready_i low has the same effect as R7. It acts through a two-flop synchronizer, so it takes effect a few clocks after it changes.
- R9: After the last word of a packet, buf_done_o pulses for one clock on that owner's bit only. The owner's buffer pointer then advances, wrapping from NUM_BUFS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 4 | Per-owner packet-ready request |
| ready_i | input | 1 | Asynchronous receiver ready, high to allow readout |
| inhibit_i | input | 1 | Readout inhibit control |
| mem_rd_o | output | 1 | Packet memory read strobe |
| mem_addr_o | output | ADDR_W | Packet memory read address |
| mem_data_i | input | WORD_W | Packet memory read data, valid in the strobe cycle |
| buf_done_o | output | 4 | Per-owner buffer-read pulse |
| tlm_clk_o | output | 1 | Telemetry clock |
| tlm_data_o | output | BYTE_W | Telemetry data byte |
| tlm_sync_n_o | output | 1 | Telemetry sync, low during a packet |

## Verification
The hardest case to reach is a halt that arrives in the middle of a packet. A short pulse is not enough: the halt has to stay on long enough to drain the byte already in flight, and then release must show that the same buffer is replayed from word 0. The bench lets one owner start, counts read strobes until a few words are out, and then raises inhibit or drops ready. With the scoreboard muted, it confirms that no reads or done pulses follow, then queues the full packet again and releases. The recovery exclusion is reached by parking requests from several owners behind inhibit, so that they all meet the first arbitration decision together.

// File: rtl/pktrd_pkg.sv
package pktrd_pkg;
    localparam int NUM_OWNERS = 4;
    localparam int OWN_W      = 2;

    typedef logic [OWN_W-1:0] owner_t;

    localparam owner_t OWN_EVENT = 2'd0;
    localparam owner_t OWN_FAST  = 2'd1;
    localparam owner_t OWN_MON   = 2'd2;
    localparam owner_t OWN_PASS  = 2'd3;

    // rank 0 is the strongest claim
    function automatic owner_t rank_owner(input int rank);
        case (rank)
            0:       return OWN_MON;
            1:       return OWN_EVENT;
            2:       return OWN_FAST;
            default: return OWN_PASS;
        endcase
    endfunction
endpackage

// File: rtl/pktrd_sync2.sv
module pktrd_sync2 #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pktrd_prio_pick.sv
module pktrd_prio_pick
    import pktrd_pkg::*;
(
    input  logic [NUM_OWNERS-1:0] req,
    input  logic [NUM_OWNERS-1:0] mask,
    output logic                  valid,
    output owner_t                win
);
    logic [NUM_OWNERS:0]   found;
    logic [OWN_W-1:0]      sel [NUM_OWNERS+1];
    logic [NUM_OWNERS-1:0] hit;

    assign found[0] = 1'b0;
    assign sel[0]   = '0;

    for (genvar r = 0; r < NUM_OWNERS; r++) begin : g_rank
        localparam owner_t O = rank_owner(r);
        assign hit[r]     = req[O] & ~mask[O];
        assign found[r+1] = found[r] | hit[r];
        assign sel[r+1]   = (found[r] || !hit[r]) ? sel[r] : O;
    end

    assign valid = found[NUM_OWNERS];
    assign win   = sel[NUM_OWNERS];
endmodule

// File: rtl/pktrd_ser.sv
module pktrd_ser #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ph,
    input  logic              rd_fire,
    input  logic              halt,
    input  logic [WORD_W-1:0] word_i,
    output logic              tlm_clk,
    output logic [BYTE_W-1:0] tlm_data,
    output logic              tlm_sync_n
);
    typedef struct packed {
        logic              tclk;
        logic [BYTE_W-1:0] data;
        logic              sync_n;
        logic [BYTE_W-1:0] lo_hold;
        logic              live;
    } ser_t;

    ser_t q, n;

    always_comb begin
        n      = q;
        n.tclk = ~ph[0];
        if (ph == 2'd0) begin
            n.lo_hold = word_i[BYTE_W-1:0];
            n.live    = rd_fire;
            n.data    = rd_fire ? word_i[WORD_W-1 -: BYTE_W] : '0;
            n.sync_n  = ~rd_fire;
        end else if (ph == 2'd2) begin
            n.data   = (q.live && !halt) ? q.lo_hold : '0;
            n.sync_n = ~(q.live & ~halt);
            n.live   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tclk: 1'b0, data: '0, sync_n: 1'b1, lo_hold: '0, live: 1'b0};
        else        q <= n;
    end

    assign tlm_clk    = q.tclk;
    assign tlm_data   = q.data;
    assign tlm_sync_n = q.sync_n;
endmodule

// File: rtl/pkt_read_serializer.sv
module pkt_read_serializer
    import pktrd_pkg::*;
#(
    parameter int  PKT_WORDS = 8,
    parameter int  NUM_BUFS  = 4,
    parameter int  WORD_W    = 16,
    localparam int BYTE_W    = WORD_W / 2,
    localparam int BUF_W     = $clog2(NUM_BUFS),
    localparam int IDX_W     = $clog2(PKT_WORDS),
    localparam int ADDR_W    = OWN_W + BUF_W + IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_OWNERS-1:0] req_i,
    input  logic                  ready_i,
    input  logic                  inhibit_i,
    output logic                  mem_rd_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    input  logic [WORD_W-1:0]     mem_data_i,
    output logic [NUM_OWNERS-1:0] buf_done_o,
    output logic                  tlm_clk_o,
    output logic [BYTE_W-1:0]     tlm_data_o,
    output logic                  tlm_sync_n_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);
    localparam logic [BUF_W-1:0] LAST_BUF = BUF_W'(NUM_BUFS - 1);

    typedef struct packed {
        logic [1:0]                       ph;
        logic                             active;
        owner_t                           owner;
        logic [IDX_W-1:0]                 idx;
        owner_t                           last;
        logic                             gap;
        logic [NUM_OWNERS-1:0][BUF_W-1:0] rptr;
        logic [NUM_OWNERS-1:0]            done;
    } st_t;

    st_t q, n;

    logic                  ready_s;
    logic                  halt;
    logic [NUM_OWNERS-1:0] mask;
    logic                  pick_v;
    owner_t                pick_w;
    owner_t                cur_owner;
    logic [IDX_W-1:0]      cur_idx;
    logic                  rd_fire;

    pktrd_sync2 #(.STAGES(2), .RST_VAL(1'b0)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ready_i),
        .q     (ready_s)
    );

    assign halt = inhibit_i | ~ready_s;
    assign mask = q.gap ? (NUM_OWNERS'(1) << q.last) : '0;

    pktrd_prio_pick u_pick (
        .req   (req_i),
        .mask  (mask),
        .valid (pick_v),
        .win   (pick_w)
    );

    always_comb begin
        n         = q;
        n.ph      = q.ph + 2'd1;
        n.done    = '0;
        rd_fire   = 1'b0;
        cur_owner = q.active ? q.owner : pick_w;
        cur_idx   = q.active ? q.idx : '0;

        if (halt) begin
            n.active = 1'b0;
            n.idx    = '0;
            n.gap    = 1'b0;
        end else if (q.ph == 2'd0) begin
            n.gap = 1'b0;
            if (q.active || pick_v) begin
                rd_fire  = 1'b1;
                n.active = 1'b1;
                n.owner  = cur_owner;
                if (cur_idx == LAST_IDX) begin
                    n.active          = 1'b0;
                    n.idx             = '0;
                    n.done[cur_owner] = 1'b1;
                    n.last            = cur_owner;
                    n.gap             = 1'b1;
                    n.rptr[cur_owner] = (q.rptr[cur_owner] == LAST_BUF) ? '0
                                        : q.rptr[cur_owner] + BUF_W'(1);
                end else begin
                    n.idx = cur_idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign mem_rd_o   = rd_fire;
    assign mem_addr_o = {cur_owner, q.rptr[cur_owner], cur_idx};
    assign buf_done_o = q.done;

    pktrd_ser #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (q.ph),
        .rd_fire    (rd_fire),
        .halt       (halt),
        .word_i     (mem_data_i),
        .tlm_clk    (tlm_clk_o),
        .tlm_data   (tlm_data_o),
        .tlm_sync_n (tlm_sync_n_o)
    );
endmodule

// File: rtl/pktrd_checks.sv
module pktrd_checks #(
    parameter int NUM_OWNERS = 4,
    parameter int BYTE_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  inhibit_i,
    input logic                  mem_rd_o,
    input logic [NUM_OWNERS-1:0] buf_done_o,
    input logic                  tlm_clk_o,
    input logic [BYTE_W-1:0]     tlm_data_o,
    input logic                  tlm_sync_n_o
);
    p_done_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_done_o));

    p_done_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_done_o) |-> $past(mem_rd_o));

    p_no_read_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |-> !mem_rd_o);

    p_read_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    p_byte_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tlm_clk_o) |-> ($stable(tlm_data_o) && $stable(tlm_sync_n_o)));

    p_sync_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tlm_sync_n_o) |-> $past(mem_rd_o));
endmodule

bind pkt_read_serializer pktrd_checks #(.NUM_OWNERS(4), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit_i    (inhibit_i),
    .mem_rd_o     (mem_rd_o),
    .buf_done_o   (buf_done_o),
    .tlm_clk_o    (tlm_clk_o),
    .tlm_data_o   (tlm_data_o),
    .tlm_sync_n_o (tlm_sync_n_o)
);

// File: tb/sim_pkt_read_serializer.sv
module sim_pkt_read_serializer;
    localparam int PKT_WORDS = 8;
    localparam int NUM_BUFS  = 4;
    localparam int ADDR_W    = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req;
    logic        ready = 1'b1;
    logic        inhibit = 1'b0;
    logic        mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_data;
    logic [3:0]  buf_done;
    logic        tlm_clk;
    logic [7:0]  tlm_data;
    logic        tlm_sync_n;

    always #10 clk = ~clk;

    pkt_read_serializer #(.PKT_WORDS(PKT_WORDS), .NUM_BUFS(NUM_BUFS), .WORD_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ready_i(ready), .inhibit_i(inhibit),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
        .buf_done_o(buf_done), .tlm_clk_o(tlm_clk), .tlm_data_o(tlm_data),
        .tlm_sync_n_o(tlm_sync_n)
    );

    function automatic logic [15:0] word_of(input logic [ADDR_W-1:0] a);
        logic [7:0] b;
        b = 8'(a);
        return {~b, b};
    endfunction

    assign mem_data = word_of(mem_addr);

    int pending [4];
    int done_cnt [4];
    int exp_buf [4];
    always_comb for (int o = 0; o < 4; o++) req[o] = (pending[o] > 0);

    logic [7:0] exp_q [$];
    bit    sb_on = 1'b1;
    string tag = "R5";
    int n_checks = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int high_run = 0;
    bit seen_low = 1'b0;
    int g2 = 0;
    int gother = 0;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // driver: expected bytes of one whole packet, high byte first
    task automatic push_pkt(input int o);
        logic [ADDR_W-1:0] a;
        logic [15:0] w;
        for (int i = 0; i < PKT_WORDS; i++) begin
            a = {2'(o), 2'(exp_buf[o]), 3'(i)};
            w = word_of(a);
            exp_q.push_back(w[15:8]);
            exp_q.push_back(w[7:0]);
        end
        exp_buf[o] = (exp_buf[o] + 1) % NUM_BUFS;
    endtask

    task automatic clear_stats();
        g2 = 0; gother = 0; seen_low = 1'b0; high_run = 0;
    endtask

    task automatic wait_idle(input string rq);
        int t;
        t = 0;
        while (((pending[0] + pending[1] + pending[2] + pending[3]) != 0 || exp_q.size() != 0) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(t < 4000, rq, "drain timeout", t, 0);
        repeat (12) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: sample on the falling telemetry clock edge, away from clk edges
    initial begin
        bit prev_t;
        prev_t = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int o = 0; o < 4; o++) if (buf_done[o]) begin
                    pending[o]--;
                    done_cnt[o]++;
                end
                if (mem_rd) rd_cnt++;
                if (prev_t && !tlm_clk) begin
                    if (!tlm_sync_n) begin
                        if (sb_on) begin
                            if (exp_q.size() == 0) begin
                                check(1'b0, "R3", "unexpected byte", int'(tlm_data), -1);
                            end else begin
                                logic [7:0] e;
                                e = exp_q.pop_front();
                                check(tlm_data == e, tag, "byte", int'(tlm_data), int'(e));
                            end
                        end
                        if (seen_low && high_run > 0 && high_run <= 4) begin
                            if (high_run == 2) g2++;
                            else gother++;
                        end
                        high_run = 0;
                        seen_low = 1'b1;
                    end else begin
                        high_run++;
                    end
                end
            end
            prev_t = tlm_clk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int d0;
        int rd0;
        for (int o = 0; o < 4; o++) begin pending[o] = 0; done_cnt[o] = 0; exp_buf[o] = 0; end
        repeat (5) @(negedge clk);
        // R1 reset state
        check(tlm_sync_n == 1'b1, "R1", "sync_n in reset", int'(tlm_sync_n), 1);
        check(tlm_clk == 1'b0, "R1", "tlm_clk in reset", int'(tlm_clk), 0);
        check(mem_rd == 1'b0, "R1", "mem_rd in reset", int'(mem_rd), 0);
        check(buf_done == 4'd0, "R1", "buf_done in reset", int'(buf_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tlm_sync_n == 1'b1 && mem_rd == 1'b0, "R1", "idle after reset", int'(tlm_sync_n), 1);

        // R3/R5/R6/R9: one owner, five packets, buffers 0,1,2,3 then wrap to 0
        tag = "R9";
        clear_stats();
        for (int k = 0; k < 5; k++) push_pkt(1);
        pending[1] = 5;
        wait_idle("R3");
        check(done_cnt[1] == 5, "R9", "done pulses owner 1", done_cnt[1], 5);
        check(g2 == 4, "R6", "same-owner two-clock gaps", g2, 4);
        check(gother == 0, "R6", "other short gaps", gother, 0);

        // R2: all four pending at once, order 2,0,1,3, sync stays low
        tag = "R2";
        inhibit = 1'b1;
        repeat (4) @(negedge clk);
        clear_stats();
        push_pkt(2); push_pkt(0); push_pkt(1); push_pkt(3);
        for (int o = 0; o < 4; o++) pending[o] = 1;
        repeat (4) @(negedge clk);
        inhibit = 1'b0;
        wait_idle("R2");
        check(g2 == 0 && gother == 0, "R6", "gaps between different owners", g2 + gother, 0);

        // R4: two busy owners alternate
        tag = "R4";
        inhibit = 1'b1;
        repeat (4) @(negedge clk);
        clear_stats();
        for (int k = 0; k < 3; k++) begin push_pkt(2); push_pkt(0); end
        pending[0] = 3;
        pending[2] = 3;
        repeat (4) @(negedge clk);
        inhibit = 1'b0;
        wait_idle("R4");
        check(done_cnt[0] == 4 && done_cnt[2] == 4, "R4", "done pulses owners 0 and 2", done_cnt[0] + done_cnt[2], 8);
        check(g2 == 0 && gother == 0, "R6", "gaps while alternating", g2 + gother, 0);

        // R7: inhibit in mid-packet, replay of the same buffer
        tag = "R7";
        inhibit = 1'b1;
        repeat (4) @(negedge clk);
        sb_on = 1'b0;
        pending[3] = 1;
        d0 = done_cnt[3];
        rd0 = rd_cnt;
        inhibit = 1'b0;
        while (rd_cnt < rd0 + 3) @(negedge clk);
        inhibit = 1'b1;
        repeat (12) @(negedge clk);
        rd0 = rd_cnt;
        repeat (40) @(negedge clk);
        check(rd_cnt == rd0, "R7", "reads while inhibited", rd_cnt - rd0, 0);
        check(tlm_sync_n == 1'b1, "R7", "sync while inhibited", int'(tlm_sync_n), 1);
        check(done_cnt[3] == d0, "R7", "done on aborted packet", done_cnt[3] - d0, 0);
        exp_q.delete();
        push_pkt(3);
        sb_on = 1'b1;
        inhibit = 1'b0;
        wait_idle("R7");
        check(done_cnt[3] == d0 + 1, "R7", "done after replay", done_cnt[3] - d0, 1);

        // R8: ready drop in mid-packet, replay of the same buffer
        tag = "R8";
        ready = 1'b0;
        repeat (6) @(negedge clk);
        sb_on = 1'b0;
        pending[2] = 1;
        d0 = done_cnt[2];
        rd0 = rd_cnt;
        ready = 1'b1;
        while (rd_cnt < rd0 + 3) @(negedge clk);
        ready = 1'b0;
        repeat (12) @(negedge clk);
        rd0 = rd_cnt;
        repeat (40) @(negedge clk);
        check(rd_cnt == rd0, "R8", "reads while not ready", rd_cnt - rd0, 0);
        check(tlm_sync_n == 1'b1, "R8", "sync while not ready", int'(tlm_sync_n), 1);
        check(done_cnt[2] == d0, "R8", "done on aborted packet", done_cnt[2] - d0, 0);
        exp_q.delete();
        push_pkt(2);
        sb_on = 1'b1;
        ready = 1'b1;
        wait_idle("R8");
        check(done_cnt[2] == d0 + 1, "R8", "done after replay", done_cnt[2] - d0, 1);
        check(exp_q.size() == 0, "R3", "bytes left over", exp_q.size(), 0);

        summary();
    end
endmodule